// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers a parameterised set of interrupt sources for a small processor core and decides, every cycle, whether the core should be interrupted and to which vector it must jump. Every source owns three register bits: a pending flag, a per-source enable, and a priority select. Software reaches these bits, together with a small control register, through a simple write port and a combinational read port.

There are two operating modes. In priority mode, one global enable gates high-priority sources and a second gates low-priority sources. High requests go to vector 0x000008 and low requests go to 0x000018. A high request can preempt a running low handler. In compatibility mode, the priority bits are ignored. One global enable gates everything, a second bit gates only the peripheral group, and all requests go to 0x000008.

The core answers a request with an acknowledge pulse and leaves a handler with a return pulse. The controller clears the matching global enable on acknowledge and sets it again on return. It tracks the in-service level as idle, low, high, or high nested over low.

Top module: `irq_ctrl`

## Requirements
- R1: A pulse on `evt_i[i]` sets flag i at the next clock edge, whatever the enables. A write with select 0 loads the flags, but an event in the same cycle still sets its flag.
- R2: After reset, the flag, enable, priority and control registers read zero, `irq_req_o` is low, compatibility mode is active and the level is idle.
- R3: In priority mode (control bit 0 = 1), a source whose flag, enable and priority bit (1 = high) are all set raises `irq_req_o` with vector 0x000008 only while the high enable (control bit 1) is set.
- R4: In priority mode, a source whose flag and enable are set and whose priority bit is 0 raises `irq_req_o` with vector 0x000018 only while the low enable (control bit 2) is set.
- R5: When a high and a low request are pending together, the vector is 0x000008.
- R6: In compatibility mode (control bit 0 = 0), priority bits have no effect. Control bit 1 gates every source. Control bit 2 additionally gates the sources marked in `PERIPH_MASK`. The vector is always 0x000008.
- R7: An `irq_ack_i` pulse while `irq_req_o` is high clears, at the next edge, the global enable of the level taken. In compatibility mode this is bit 1. In priority mode it is bit 1 for a high request and bit 2 for a low one. An acknowledge with no request changes nothing.
- R8: While a low handler runs, a high request is still raised and can be taken. While a high handler runs, low sources raise no request even if bit 2 is set by software.
- R9: `irq_ret_i` restores the enable of the level being left. Leaving a nested high handler returns to the low level with bit 1 set. Leaving a low handler sets bit 2. In compatibility mode a return sets bit 1.
- R10: A flag still set when its enable is restored raises `irq_req_o` again without any new event.
- R11: Read select 0, 1, 2 and 3 return the flags, enables, priorities and control bits {low enable, high enable, mode} respectively, zero extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_SRC | Source event pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write select: 0 flags, 1 enables, 2 priorities, 3 control |
| wr_data_i | input | DW | Write data |
| rd_sel_i | input | 2 | Read select, same encoding as writes |
| rd_data_o | output | DW | Read data, combinational |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | VEC_W | Vector address, valid while the request is high |
| irq_ack_i | input | 1 | Core takes the current request |
| irq_ret_i | input | 1 | Core returns from the current handler |

## Verification
Register writes, event pulses, acknowledges and returns each land in one register stage. Request and vector outputs are combinational from those registers, so every result is due one clock edge after its stimulus. The bench drives every input on a falling edge and checks the outputs at the next falling edge, half a cycle after the single rising edge that captured the change. Read data is combinational, so it is checked a short delay after the read select changes, with no extra clock.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    typedef enum logic [1:0] {
        LVL_IDLE = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_NEST = 2'd3
    } isr_lvl_e;

    typedef enum logic [1:0] {
        SEL_FLAG = 2'd0,
        SEL_EN   = 2'd1,
        SEL_PRIO = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    localparam int CTRL_W  = 3;
    localparam int CB_MODE = 0;
    localparam int CB_GHI  = 1;
    localparam int CB_GLO  = 2;

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_ctrl_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [N_SRC-1:0] wr_data_i,
    output logic [N_SRC-1:0] flag_o,
    output logic [N_SRC-1:0] en_o,
    output logic [N_SRC-1:0] prio_o
);

    typedef struct packed {
        logic [N_SRC-1:0] flag;
        logic [N_SRC-1:0] en;
        logic [N_SRC-1:0] prio;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en_i) begin
            case (wr_sel_i)
                SEL_FLAG: bank_d.flag = wr_data_i;
                SEL_EN:   bank_d.en   = wr_data_i;
                SEL_PRIO: bank_d.prio = wr_data_i;
                default:  ;
            endcase
        end
        // events win over a same-cycle software write
        bank_d.flag = bank_d.flag | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign flag_o = bank_q.flag;
    assign en_o   = bank_q.en;
    assign prio_o = bank_q.prio;

    for (genvar i = 0; i < N_SRC; i++) begin : g_flag_chk
        // R1
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> flag_o[i]);
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_ctrl_pkg::*;
#(
    parameter int               N_SRC       = 8,
    parameter logic [N_SRC-1:0] PERIPH_MASK = '1,
    parameter int               VEC_W       = 24,
    parameter logic [VEC_W-1:0] HI_VEC      = 'h8,
    parameter logic [VEC_W-1:0] LO_VEC      = 'h18
) (
    input  logic [N_SRC-1:0] flag_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic [N_SRC-1:0] prio_i,
    input  logic             mode_i,
    input  logic             ghi_i,
    input  logic             glo_i,
    input  isr_lvl_e         lvl_i,
    output logic             req_o,
    output logic             take_hi_o,
    output logic [VEC_W-1:0] vec_o
);

    logic [N_SRC-1:0] armed;
    logic             hi_any;
    logic             lo_any;
    logic             hi_busy;

    always_comb begin
        armed   = flag_i & en_i;
        hi_busy = (lvl_i == LVL_HIGH) || (lvl_i == LVL_NEST);
        if (mode_i) begin
            hi_any = ghi_i && |(armed & prio_i);
            lo_any = glo_i && !hi_busy && |(armed & ~prio_i);
        end else begin
            hi_any = ghi_i && |(armed & (~PERIPH_MASK | {N_SRC{glo_i}}));
            lo_any = 1'b0;
        end
        req_o     = hi_any || lo_any;
        take_hi_o = hi_any;
        vec_o     = (lo_any && !hi_any) ? LO_VEC : HI_VEC;
    end

endmodule

// File: rtl/irq_level_ctl.sv
module irq_level_ctl
    import irq_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    input  logic              ack_i,
    input  logic              ret_i,
    input  logic              req_i,
    input  logic              take_hi_i,
    output logic              mode_o,
    output logic              ghi_o,
    output logic              glo_o,
    output isr_lvl_e          lvl_o
);

    typedef struct packed {
        logic     mode;
        logic     ghi;
        logic     glo;
        isr_lvl_e lvl;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en_i && (wr_sel_i == SEL_CTRL)) begin
            ctl_d.mode = wr_data_i[CB_MODE];
            ctl_d.ghi  = wr_data_i[CB_GHI];
            ctl_d.glo  = wr_data_i[CB_GLO];
        end
        if (ack_i && req_i) begin
            if (!ctl_q.mode) begin
                ctl_d.ghi = 1'b0;
                ctl_d.lvl = LVL_HIGH;
            end else if (take_hi_i) begin
                ctl_d.ghi = 1'b0;
                ctl_d.lvl = (ctl_q.lvl == LVL_LOW) ? LVL_NEST : LVL_HIGH;
            end else begin
                ctl_d.glo = 1'b0;
                ctl_d.lvl = LVL_LOW;
            end
        end else if (ret_i) begin
            case (ctl_q.lvl)
                LVL_NEST: begin
                    ctl_d.ghi = 1'b1;
                    ctl_d.lvl = LVL_LOW;
                end
                LVL_HIGH: begin
                    ctl_d.ghi = 1'b1;
                    ctl_d.lvl = LVL_IDLE;
                end
                LVL_LOW: begin
                    ctl_d.glo = 1'b1;
                    ctl_d.lvl = LVL_IDLE;
                end
                default: begin
                    if (!ctl_q.mode) ctl_d.ghi = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{mode: 1'b0, ghi: 1'b0, glo: 1'b0, lvl: LVL_IDLE};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mode_o = ctl_q.mode;
    assign ghi_o  = ctl_q.ghi;
    assign glo_o  = ctl_q.glo;
    assign lvl_o  = ctl_q.lvl;

    // R7
    gen_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && req_i && (!mode_o || take_hi_i)) |=> !ghi_o);

    // R7
    lo_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && req_i && mode_o && !take_hi_i) |=> (!glo_o && lvl_o == LVL_LOW));

    // R9
    nest_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !(ack_i && req_i) && lvl_o == LVL_NEST && !(wr_en_i && wr_sel_i == SEL_CTRL))
        |=> (lvl_o == LVL_LOW && ghi_o));

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int               N_SRC       = 8,
    parameter logic [N_SRC-1:0] PERIPH_MASK = 8'hF0,
    parameter int               VEC_W       = 24,
    parameter logic [VEC_W-1:0] HI_VEC      = 24'h000008,
    parameter logic [VEC_W-1:0] LO_VEC      = 24'h000018,
    localparam int              DW          = (N_SRC > CTRL_W) ? N_SRC : CTRL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [DW-1:0]    wr_data_i,
    input  logic [1:0]       rd_sel_i,
    output logic [DW-1:0]    rd_data_o,
    output logic             irq_req_o,
    output logic [VEC_W-1:0] irq_vec_o,
    input  logic             irq_ack_i,
    input  logic             irq_ret_i
);

    logic [N_SRC-1:0] flag, en, prio;
    logic             mode, ghi, glo, take_hi;
    isr_lvl_e         lvl;

    irq_src_bank #(.N_SRC(N_SRC)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i[N_SRC-1:0]),
        .flag_o    (flag),
        .en_o      (en),
        .prio_o    (prio)
    );

    irq_level_ctl u_lvl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i[CTRL_W-1:0]),
        .ack_i     (irq_ack_i),
        .ret_i     (irq_ret_i),
        .req_i     (irq_req_o),
        .take_hi_i (take_hi),
        .mode_o    (mode),
        .ghi_o     (ghi),
        .glo_o     (glo),
        .lvl_o     (lvl)
    );

    irq_arbiter #(
        .N_SRC       (N_SRC),
        .PERIPH_MASK (PERIPH_MASK),
        .VEC_W       (VEC_W),
        .HI_VEC      (HI_VEC),
        .LO_VEC      (LO_VEC)
    ) u_arb (
        .flag_i    (flag),
        .en_i      (en),
        .prio_i    (prio),
        .mode_i    (mode),
        .ghi_i     (ghi),
        .glo_i     (glo),
        .lvl_i     (lvl),
        .req_o     (irq_req_o),
        .take_hi_o (take_hi),
        .vec_o     (irq_vec_o)
    );

    always_comb begin
        rd_data_o = '0;
        case (rd_sel_i)
            SEL_FLAG: rd_data_o[N_SRC-1:0] = flag;
            SEL_EN:   rd_data_o[N_SRC-1:0] = en;
            SEL_PRIO: rd_data_o[N_SRC-1:0] = prio;
            default:  rd_data_o[CTRL_W-1:0] = {glo, ghi, mode};
        endcase
    end

    // R8
    low_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl == LVL_HIGH || lvl == LVL_NEST) && mode && irq_req_o) |-> (irq_vec_o == HI_VEC));

    // R6
    compat_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && irq_req_o) |-> (irq_vec_o == HI_VEC));

endmodule

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;

    localparam int N_SRC = 8;
    localparam int DW    = 8;
    localparam int VEC_W = 24;
    localparam int NTBL  = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_SRC-1:0] evt_i = '0;
    logic             wr_en_i = 1'b0;
    logic [1:0]       wr_sel_i = '0;
    logic [DW-1:0]    wr_data_i = '0;
    logic [1:0]       rd_sel_i = '0;
    logic [DW-1:0]    rd_data_o;
    logic             irq_req_o;
    logic [VEC_W-1:0] irq_vec_o;
    logic             irq_ack_i = 1'b0;
    logic             irq_ret_i = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .rd_sel_i  (rd_sel_i),
        .rd_data_o (rd_data_o),
        .irq_req_o (irq_req_o),
        .irq_vec_o (irq_vec_o),
        .irq_ack_i (irq_ack_i),
        .irq_ret_i (irq_ret_i)
    );

    // {mode, hi_en, lo_en, flags, enables, prios, exp_req, exp_vec[7:0]}
    localparam logic [35:0] TBL [0:NTBL-1] = '{
        {1'b1, 1'b1, 1'b0, 8'h01, 8'h01, 8'h01, 1'b1, 8'h08},  // R3
        {1'b1, 1'b0, 1'b1, 8'h01, 8'h01, 8'h01, 1'b0, 8'h00},  // R3 gated
        {1'b1, 1'b0, 1'b1, 8'h02, 8'h02, 8'h00, 1'b1, 8'h18},  // R4
        {1'b1, 1'b1, 1'b0, 8'h02, 8'h02, 8'h00, 1'b0, 8'h00},  // R4 gated
        {1'b1, 1'b1, 1'b1, 8'h03, 8'h03, 8'h01, 1'b1, 8'h08},  // R5
        {1'b1, 1'b1, 1'b1, 8'h03, 8'h01, 8'h02, 1'b1, 8'h18},  // R4 unenabled high
        {1'b0, 1'b1, 1'b0, 8'h01, 8'h01, 8'h00, 1'b1, 8'h08},  // R6 prio ignored
        {1'b0, 1'b1, 1'b0, 8'h10, 8'h10, 8'h10, 1'b0, 8'h00},  // R6 periph gated
        {1'b0, 1'b1, 1'b1, 8'h10, 8'h10, 8'h00, 1'b1, 8'h08},  // R6 periph open
        {1'b0, 1'b0, 1'b1, 8'h10, 8'h10, 8'h00, 1'b0, 8'h00},  // R6 global off
        {1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 8'hFF, 1'b0, 8'h00}   // R3 no flags
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] sel, input logic [7:0] exp, input string tag);
        rd_sel_i = sel;
        #1;
        check(tag, {24'h0, rd_data_o}, {24'h0, exp});
    endtask

    task automatic pulse(input logic ack, input logic ret);
        @(negedge clk);
        irq_ack_i = ack; irq_ret_i = ret;
        @(negedge clk);
        irq_ack_i = 1'b0; irq_ret_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        #1;
        check("R2 req", {31'h0, irq_req_o}, 32'h0);
        for (int s = 0; s < 4; s++) rd_chk(s[1:0], 8'h00, "R2 regs");

        // R1 event sets flag with everything disabled
        @(negedge clk); evt_i = 8'h08;
        @(negedge clk); evt_i = '0;
        rd_chk(2'd0, 8'h08, "R1 event");
        check("R1 no req", {31'h0, irq_req_o}, 32'h0);
        // R1 event wins over same-cycle flag write
        @(negedge clk); evt_i = 8'h20; wr_en_i = 1'b1; wr_sel_i = 2'd0; wr_data_i = 8'h00;
        @(negedge clk); evt_i = '0; wr_en_i = 1'b0;
        rd_chk(2'd0, 8'h20, "R1 event vs write");

        // table walk: R3..R6, R11
        for (int k = 0; k < NTBL; k++) begin
            wr(2'd3, {5'd0, TBL[k][33], TBL[k][34], TBL[k][35]});
            wr(2'd0, TBL[k][32:25]);
            wr(2'd1, TBL[k][24:17]);
            wr(2'd2, TBL[k][16:9]);
            #1;
            check($sformatf("R3-6 table %0d req", k), {31'h0, irq_req_o}, {31'h0, TBL[k][8]});
            if (TBL[k][8])
                check($sformatf("R5 table %0d vec", k), {8'h0, irq_vec_o}, {24'h0, TBL[k][7:0]});
            rd_chk(2'd0, TBL[k][32:25], "R11 flags");
            rd_chk(2'd1, TBL[k][24:17], "R11 enables");
            rd_chk(2'd2, TBL[k][16:9], "R11 prios");
            rd_chk(2'd3, {5'd0, TBL[k][33], TBL[k][34], TBL[k][35]}, "R11 ctrl");
        end

        // compatibility: acknowledge and return
        do_reset();
        wr(2'd3, 8'h02);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h01);
        #1;
        check("R6 compat req", {31'h0, irq_req_o}, 32'h1);
        check("R6 compat vec", irq_vec_o, 32'h8);
        pulse(1'b1, 1'b0);
        check("R7 compat req drop", {31'h0, irq_req_o}, 32'h0);
        rd_chk(2'd3, 8'h00, "R7 compat enable cleared");
        pulse(1'b0, 1'b1);
        rd_chk(2'd3, 8'h02, "R9 compat enable restored");
        check("R10 compat retrigger", {31'h0, irq_req_o}, 32'h1);
        wr(2'd0, 8'h00);
        pulse(1'b1, 1'b0);
        rd_chk(2'd3, 8'h02, "R7 ack without request ignored");

        // priority mode: low handler preempted by high
        do_reset();
        wr(2'd3, 8'h07);
        wr(2'd2, 8'h01);
        wr(2'd1, 8'h03);
        wr(2'd0, 8'h02);
        #1;
        check("R4 low req", {31'h0, irq_req_o}, 32'h1);
        check("R4 low vec", irq_vec_o, 32'h18);
        pulse(1'b1, 1'b0);
        check("R7 low taken", {31'h0, irq_req_o}, 32'h0);
        rd_chk(2'd3, 8'h03, "R7 low enable cleared");
        wr(2'd0, 8'h03);
        #1;
        check("R8 preempt req", {31'h0, irq_req_o}, 32'h1);
        check("R8 preempt vec", irq_vec_o, 32'h8);
        pulse(1'b1, 1'b0);
        check("R7 high taken", {31'h0, irq_req_o}, 32'h0);
        rd_chk(2'd3, 8'h01, "R7 high enable cleared");
        wr(2'd3, 8'h05);
        #1;
        check("R8 low blocked in high", {31'h0, irq_req_o}, 32'h0);
        wr(2'd3, 8'h01);
        wr(2'd0, 8'h02);
        pulse(1'b0, 1'b1);
        rd_chk(2'd3, 8'h03, "R9 nested return");
        check("R9 still in low", {31'h0, irq_req_o}, 32'h0);
        pulse(1'b0, 1'b1);
        rd_chk(2'd3, 8'h07, "R9 low return");
        check("R10 low retrigger", {31'h0, irq_req_o}, 32'h1);
        check("R10 low retrigger vec", irq_vec_o, 32'h18);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule